// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This unit keeps the interrupt status byte and the interrupt enable mask of a packet-buffer network controller and drives one level-sensitive interrupt line towards the host. Each status bit has its own source. Some bits latch one-cycle event pulses from the buffer manager: allocation complete, frame received and receive overrun. Other bits are forced on by queue levels: transmit queue empty and completion queue holding entries. A forced bit stays set after its level goes away, until software acknowledges it.

Software reaches the unit through one write port with two targets, the acknowledge register and the mask register. An acknowledge clears only the bits that are both written as one and in the acknowledgeable set. When an acknowledge selects the transmit-done bit, the unit also raises a one-cycle request that pops the completion queue. The queue-level inputs give the state of each queue after any pop made in the same cycle. The forced bits are therefore evaluated after the acknowledge has taken effect.

Top module: `intr_status_unit`

## Requirements
- R1: During and after a synchronous reset, with no input active, the status byte is 0x04, the mask byte is 0x00 and irq is low.
- R2: Bit 2 (0x04, transmit empty) is set in the cycle after `tx_fifo_empty` is high. It stays set after the queue fills, until an acknowledge clears it while the queue is not empty.
- R3: Bit 1 (0x02, transmit done) is set in the cycle after `done_fifo_nonempty` is high. It stays set until an acknowledge clears it while the completion queue is empty.
- R4: An acknowledge write of value V clears exactly the status bits set in V AND 0xD6. Bit 0 (receive) and bit 3 (allocation) are never changed by an acknowledge.
- R5: `done_pop` is high in exactly those cycles that carry an acknowledge write with bit 1 of the data set.
- R6: Bit 3 (0x08, allocation done) is set by `alloc_done` and cleared by `alloc_req`. When both arrive in the same cycle, the set wins.
- R7: Bit 4 (0x10, receive overrun) is set by `overrun` and can be cleared by an acknowledge.
- R8: Bit 0 (0x01, receive) is set by `rx_event`. On `rx_pop` it takes the value of `rx_fifo_nonempty`, and a same-cycle `rx_event` wins over the pop.
- R9: A mask write (`reg_sel` = 1) stores the written byte, which shows on `int_mask` in the next cycle. An acknowledge write (`reg_sel` = 0) leaves the mask unchanged.
- R10: `irq` is high exactly when the status byte AND the mask byte is non-zero, in the same cycle as both bytes.
- R11: An acknowledge of bit 1 while the completion queue still holds entries after the pop leaves bit 1 set. Bits 5 to 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_fifo_empty | input | 1 | Transmit queue holds no entries |
| done_fifo_nonempty | input | 1 | Completion queue holds entries after any same-cycle pop |
| rx_fifo_nonempty | input | 1 | Receive queue holds entries after any same-cycle pop |
| alloc_req | input | 1 | New allocation requested; clears the allocation bit |
| alloc_done | input | 1 | Allocation finished pulse |
| rx_event | input | 1 | Frame received pulse |
| rx_pop | input | 1 | Receive queue head removed pulse |
| overrun | input | 1 | Receive overrun pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 acknowledge, 1 mask |
| reg_wdata | input | 8 | Write data |
| int_status | output | 8 | Interrupt status byte |
| int_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Level interrupt request |
| done_pop | output | 1 | Pop request to the completion queue |

## Verification
The hardest case to reach is an acknowledge of the transmit-done bit while the completion queue holds more than one entry. The bit must stay set until the last pop, so the forced level has to be seen after the pop and not before it. The bench keeps its own queue depths and derives the queue-level inputs from them, taking off its own prediction of the pop in the same cycle. It then acknowledges a two-entry queue twice in a row. Colliding pulses (set against clear, receive against pop) and an all-ones acknowledge are driven in single cycles to fix the priorities.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int STAT_W = 8;

    // status bit positions (software decodes these)
    localparam int B_RX      = 0;
    localparam int B_TXDONE  = 1;
    localparam int B_TXEMPTY = 2;
    localparam int B_ALLOC   = 3;
    localparam int B_OVRN    = 4;

    localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
    localparam logic [STAT_W-1:0] STAT_RESET    = 8'h04;
    localparam logic [STAT_W-1:0] MASK_RESET    = 8'h00;

    typedef enum logic {
        SEL_ACK  = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    // per-bit update controls for the status bank
    typedef struct packed {
        logic [STAT_W-1:0] clr;
        logic [STAT_W-1:0] load_en;
        logic [STAT_W-1:0] load_val;
        logic [STAT_W-1:0] set;
        logic [STAT_W-1:0] force_on;
    } bit_ctl_t;

    // clear or load first, then latch events, then apply level forcing
    function automatic logic next_bit(input logic cur, input logic clr,
                                      input logic load_en, input logic load_val,
                                      input logic set, input logic force_on);
        logic base;
        base = load_en ? load_val : (cur & ~clr);
        return base | set | force_on;
    endfunction

endpackage

// File: rtl/isu_status_bank.sv
module isu_status_bank
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bit_ctl_t          ctl,
    output logic [STAT_W-1:0] stat_d,
    output logic [STAT_W-1:0] stat_q
);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        assign stat_d[i] = next_bit(stat_q[i], ctl.clr[i], ctl.load_en[i],
                                    ctl.load_val[i], ctl.set[i], ctl.force_on[i]);

        always_ff @(posedge clk) begin
            if (rst) stat_q[i] <= STAT_RESET[i];
            else     stat_q[i] <= stat_d[i];
        end
    end

endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] mask_d,
    output logic [STAT_W-1:0] mask_q
);

    assign mask_d = wr ? wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= MASK_RESET;
        else     mask_q <= mask_d;
    end

endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_d,
    input  logic [STAT_W-1:0] mask_d,
    output logic              irq_q
);

    // registered from next-state so the line lines up with the bytes
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(stat_d & mask_d);
    end

endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
    import isu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_fifo_empty,
    input  logic       done_fifo_nonempty,
    input  logic       rx_fifo_nonempty,
    input  logic       alloc_req,
    input  logic       alloc_done,
    input  logic       rx_event,
    input  logic       rx_pop,
    input  logic       overrun,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] int_status,
    output logic [7:0] int_mask,
    output logic       irq,
    output logic       done_pop
);

    logic              ack_wr;
    logic              mask_wr;
    bit_ctl_t          ctl;
    logic [STAT_W-1:0] stat_d;
    logic [STAT_W-1:0] mask_d;

    assign ack_wr  = reg_wr && (reg_sel_e'(reg_sel) == SEL_ACK);
    assign mask_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK);

    // acknowledging transmit-done also pops the completion queue
    assign done_pop = ack_wr && reg_wdata[B_TXDONE];

    always_comb begin
        ctl          = '0;
        ctl.clr      = ack_wr ? (reg_wdata & ACK_CLEARABLE) : '0;
        ctl.clr[B_ALLOC]       = alloc_req;
        ctl.load_en[B_RX]      = rx_pop;
        ctl.load_val[B_RX]     = rx_fifo_nonempty;
        ctl.set[B_RX]          = rx_event;
        ctl.set[B_ALLOC]       = alloc_done;
        ctl.set[B_OVRN]        = overrun;
        ctl.force_on[B_TXEMPTY] = tx_fifo_empty;
        ctl.force_on[B_TXDONE]  = done_fifo_nonempty;
    end

    isu_status_bank u_status (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .stat_d (stat_d),
        .stat_q (int_status)
    );

    isu_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr     (mask_wr),
        .wdata  (reg_wdata),
        .mask_d (mask_d),
        .mask_q (int_mask)
    );

    isu_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .stat_d (stat_d),
        .mask_d (mask_d),
        .irq_q  (irq)
    );

    // ---------------- assertions ----------------
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1 && !rst) begin
            a_r1_reset_value: assert (int_mask == 8'h00 && int_status[7:3] == 5'b0
                                      && int_status[B_TXEMPTY])
                else $error("R1 reset value");
        end
    end

    a_r2_txempty_forced: assert property (@(posedge clk) disable iff (rst)
        tx_fifo_empty |=> int_status[B_TXEMPTY]);

    a_r3_txdone_forced: assert property (@(posedge clk) disable iff (rst)
        done_fifo_nonempty |=> int_status[B_TXDONE]);

    a_r4_rx_not_acked: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !rx_pop && int_status[B_RX]) |=> int_status[B_RX]);

    a_r4_alloc_not_acked: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !alloc_req && int_status[B_ALLOC]) |=> int_status[B_ALLOC]);

    a_r6_alloc_set_wins: assert property (@(posedge clk) disable iff (rst)
        alloc_done |=> int_status[B_ALLOC]);

    a_r3_txdone_fall_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(int_status[B_TXDONE]) |-> $past(done_pop));

    a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq == |(int_status & int_mask));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        int_status[7:5] == 3'b000);

endmodule

// File: tb/test_intr_status_unit.sv
module test_intr_status_unit;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       tx_fifo_empty, done_fifo_nonempty, rx_fifo_nonempty;
    logic       alloc_req, alloc_done, rx_event, rx_pop, overrun;
    logic       reg_wr, reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] int_status, int_mask;
    logic       irq, done_pop;

    intr_status_unit i_intr_status_unit (
        .clk(clk), .rst(rst),
        .tx_fifo_empty(tx_fifo_empty), .done_fifo_nonempty(done_fifo_nonempty),
        .rx_fifo_nonempty(rx_fifo_nonempty),
        .alloc_req(alloc_req), .alloc_done(alloc_done),
        .rx_event(rx_event), .rx_pop(rx_pop), .overrun(overrun),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .int_status(int_status), .int_mask(int_mask), .irq(irq), .done_pop(done_pop)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string req = "R1";

    // behavioural model state
    int       tx_depth = 0, done_depth = 0, rx_depth = 0;
    bit [7:0] m_stat = 8'h04, m_mask = 8'h00;

    task automatic check(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_req = 0; alloc_done = 0; rx_event = 0; rx_pop = 0; overrun = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = 8'h00;
    endtask

    task automatic ack(input bit [7:0] v);
        reg_wr = 1; reg_sel = 0; reg_wdata = v;
    endtask

    task automatic wmask(input bit [7:0] v);
        reg_wr = 1; reg_sel = 1; reg_wdata = v;
    endtask

    // one clock: stimulus already set (at negedge); model, step, compare
    task automatic tick();
        bit       pop_exp, rxpop_ok;
        int       done_after, rx_after;
        bit [7:0] nxt;
        pop_exp    = reg_wr && !reg_sel && reg_wdata[1];
        done_after = done_depth - ((pop_exp && done_depth > 0) ? 1 : 0);
        rx_after   = rx_depth + (rx_event ? 1 : 0);
        rxpop_ok   = rx_pop && rx_after > 0;
        rx_after   = rx_after - (rxpop_ok ? 1 : 0);
        tx_fifo_empty      = (tx_depth == 0);
        done_fifo_nonempty = (done_after > 0);
        rx_fifo_nonempty   = (rx_after > 0);
        #1;
        check("done_pop", done_pop, pop_exp);
        // expected next status from the requirements
        nxt = m_stat;
        if (reg_wr && !reg_sel) nxt = nxt & ~(reg_wdata & 8'hD6);
        if (alloc_req) nxt[3] = 0;
        if (rx_pop) nxt[0] = (rx_after > 0);
        if (rx_event) nxt[0] = 1;
        if (alloc_done) nxt[3] = 1;
        if (overrun) nxt[4] = 1;
        if (tx_depth == 0) nxt[2] = 1;
        if (done_after > 0) nxt[1] = 1;
        if (reg_wr && reg_sel) m_mask = reg_wdata;
        m_stat = nxt;
        done_depth = done_after;
        rx_depth = rx_after;
        @(posedge clk);
        @(negedge clk);
        check("status", int_status, m_stat);
        check("mask", int_mask, m_mask);
        check("irq", irq, (m_stat & m_mask) != 0);
        idle_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        tx_fifo_empty = 1; done_fifo_nonempty = 0; rx_fifo_nonempty = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req = "R1";
        check("status", int_status, 8'h04);
        check("mask", int_mask, 8'h00);
        check("irq", irq, 0);
        rst = 0;
        tick();

        // R9: mask writes, ack does not alter mask
        req = "R9";
        wmask(8'hFF); tick();
        wmask(8'h10); tick();
        ack(8'h00); tick();

        // R2: transmit-empty sticky, acked only when queue not empty
        req = "R2";
        ack(8'h04); tick();          // queue empty: re-forced
        tx_depth = 1; tick();
        ack(8'h04); tick();          // now clears
        tick();
        tx_depth = 0; tick();

        // R7: overrun set and acked, irq via mask 0x10 (R10)
        req = "R7";
        overrun = 1; tick();
        req = "R10";
        tick();
        req = "R7";
        ack(8'h10); tick();

        // R6: alloc set, clear, collision
        req = "R6";
        wmask(8'h08); tick();
        alloc_done = 1; tick();
        alloc_req = 1; tick();
        alloc_done = 1; alloc_req = 1; tick();
        alloc_req = 1; tick();

        // R8: receive bit with pop semantics
        req = "R8";
        rx_event = 1; tick();
        rx_event = 1; tick();
        rx_pop = 1; tick();          // one left: stays set
        rx_pop = 1; tick();          // empty: clears
        rx_event = 1; rx_pop = 1; tick();
        rx_pop = 1; tick();

        // R3, R5, R11: completion queue with two entries
        req = "R3";
        wmask(8'h02); tick();
        done_depth = 2; tick();
        req = "R11";
        ack(8'h02); tick();          // one entry left: bit stays set
        req = "R5";
        ack(8'h02); tick();          // last entry popped: bit clears
        ack(8'h02); tick();          // empty queue pop request still issued
        req = "R3";
        done_depth = 1; tick();
        tick();

        // R4: all-ones ack keeps receive and allocation bits
        req = "R4";
        rx_event = 1; alloc_done = 1; overrun = 1; tx_depth = 1; tick();
        wmask(8'hFF); tick();
        ack(8'hFF); tick();
        ack(8'h29); tick();
        req = "R11";
        ack(8'hE0); tick();
        req = "R10";
        wmask(8'h00); tick();
        wmask(8'h01); tick();

        // reset mid-run returns to R1 state
        req = "R1";
        rst = 1; tx_depth = 0; done_depth = 0; rx_depth = 0;
        m_stat = 8'h04; m_mask = 8'h00;
        @(posedge clk);
        @(negedge clk);
        check("status", int_status, 8'h04);
        check("mask", int_mask, 8'h00);
        check("irq", irq, 0);
        rst = 0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule